// File: doc/BRIEF.md
# Write-Once Flash Timing Prescaler

This block turns the oscillator clock into the slow timing base that a flash controller uses to pace its program and erase steps. Software picks a 7-bit divider so that the timing base lands near 1 MHz. The block then issues a one-cycle enable pulse in the oscillator domain once every divider+1 oscillator cycles. The flash sequencer downstream counts these pulses, and it holds off until the divider-valid output goes high.

The divider sits in a single 8-bit register on a small bus port that uses address, write enable, write data and combinational read data. The divider field takes effect only once after reset. Bit 7 is a read-only flag that goes high when that write lands. A write is refused while a flash command is running, and such a refusal uses up nothing. While the reset sequence is active, a write is accepted even if a command is shown as running.

Top module: `flash_tick_prescaler`

## Requirements
- R1: After reset, the register at offset 0 reads 0x00, div_valid_o is 0 and tick_o is 0.
- R2: The first accepted write to offset 0 stores wdata bits 6:0 in register bits 6:0. The new value can be read from the cycle after the write edge.
- R3: Once a write has been accepted, every later write to offset 0 leaves bits 6:0 unchanged until the next reset.
- R4: Bit 7 reads 1 from the cycle after an accepted write until the next reset, whatever wdata bit 7 held. Software can neither set it nor clear it directly.
- R5: A write with cmd_busy_i=1 and rst_seq_i=0 changes nothing. The flag stays 0, and a later accepted write still stores its value.
- R6: A write with rst_seq_i=1 is accepted whatever cmd_busy_i is.
- R7: After the accepting edge, tick_o is 1 in cycle k (k=0 is the first cycle after that edge) exactly when k mod (D+1) equals D, where D is the stored divider. The pulse lasts one cycle, so the period is D+1 cycles.
- R8: tick_o stays 0 while the flag is 0, and div_valid_o always equals the flag.
- R9: A write to any offset other than 0 has no effect, and reads at other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr: {flag, divider} at offset 0, otherwise 0 |
| cmd_busy_i | input | 1 | A flash command is running (command-complete low) |
| rst_seq_i | input | 1 | The flash reset sequence is running |
| tick_o | output | 1 | One-cycle timing enable pulse |
| div_valid_o | output | 1 | Divider loaded; timing base is running |

## Verification
The assertions assume that cmd_busy_i and rst_seq_i are synchronous to the oscillator clock and are stable around each edge. They also assume that bus_we is a single-cycle strobe whose address and data are valid in the same cycle. The bench drives every input just after the falling edge and changes nothing between one rising edge and the next falling edge, so each write is sampled once at one rising edge. Busy and reset-sequence levels change only between writes, which means the gate assertions always see steady control inputs.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

    // Outcome of a bus write aimed at the divider register
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_ACCEPT  = 2'd1,
        WR_BUSY    = 2'd2,
        WR_LOCKED  = 2'd3
    } wr_verdict_e;

endpackage

// File: rtl/fcp_wr_gate.sv
module fcp_wr_gate
    import fcp_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned OFFSET = 0
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    input  logic              rst_seq_i,
    input  logic              locked_i,
    output wr_verdict_e       verdict_o,
    output logic              accept_o
);
    localparam logic [ADDR_W-1:0] OFFS_A = ADDR_W'(OFFSET);

    always_comb begin
        verdict_o = WR_NONE;
        if (we_i && (addr_i == OFFS_A)) begin
            if (locked_i) begin
                verdict_o = WR_LOCKED;
            end else if (busy_i && !rst_seq_i) begin
                verdict_o = WR_BUSY;
            end else begin
                verdict_o = WR_ACCEPT;
            end
        end
        accept_o = (verdict_o == WR_ACCEPT);
    end

endmodule

// File: rtl/fcp_div_reg.sv
module fcp_div_reg #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [DIV_W-1:0] wdata_i,
    input  logic             sel_i,
    input  logic             busy_i,
    input  logic             rst_seq_i,
    input  logic             we_i,
    output logic [DIV_W-1:0] div_o,
    output logic             loaded_o
);
    typedef struct packed {
        logic             loaded;
        logic [DIV_W-1:0] div;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (accept_i) begin
            state_d.div    = wdata_i;
            state_d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign div_o    = state_q.div;
    assign loaded_o = state_q.loaded;

    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.loaded |=> $stable(state_q.div)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.loaded |=> state_q.loaded); // R4

    AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.loaded && we_i && sel_i && busy_i && !rst_seq_i) |=> !state_q.loaded); // R5

    AST_SEQ_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.loaded && we_i && sel_i && rst_seq_i) |=> state_q.loaded); // R6

endmodule

// File: rtl/fcp_tick_gen.sv
module fcp_tick_gen #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       hit;

    always_comb begin
        hit     = en_i && (state_q.cnt == div_i);
        state_d = state_q;
        if (!en_i || hit) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tick_o = hit;

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !tick_o); // R8

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> !tick_o); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (state_q.cnt <= div_i)); // R7

endmodule

// File: rtl/flash_tick_prescaler.sv
module flash_tick_prescaler
    import fcp_pkg::*;
#(
    parameter int unsigned DIV_W  = 7,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned OFFSET = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DIV_W:0]      bus_wdata,
    output logic [DIV_W:0]      bus_rdata,
    input  logic                cmd_busy_i,
    input  logic                rst_seq_i,
    output logic                tick_o,
    output logic                div_valid_o
);
    localparam int unsigned      DATA_W = DIV_W + 1;
    localparam logic [ADDR_W-1:0] OFFS_A = ADDR_W'(OFFSET);

    wr_verdict_e      verdict;
    logic             accept;
    logic             loaded;
    logic             sel;
    logic [DIV_W-1:0] div_val;

    assign sel = (bus_addr == OFFS_A);

    fcp_wr_gate #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) gate_i (
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .busy_i    (cmd_busy_i),
        .rst_seq_i (rst_seq_i),
        .locked_i  (loaded),
        .verdict_o (verdict),
        .accept_o  (accept)
    );

    fcp_div_reg #(.DIV_W(DIV_W)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .wdata_i   (bus_wdata[DIV_W-1:0]),
        .sel_i     (sel),
        .busy_i    (cmd_busy_i),
        .rst_seq_i (rst_seq_i),
        .we_i      (bus_we),
        .div_o     (div_val),
        .loaded_o  (loaded)
    );

    fcp_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (loaded),
        .div_i  (div_val),
        .tick_o (tick_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel) begin
            bus_rdata = {loaded, div_val};
        end
    end

    assign div_valid_o = loaded;

    AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == WR_ACCEPT) |-> (bus_we && sel && !loaded)); // R2

    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded && bus_we && !sel) |=> !div_valid_o); // R9

    AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (bus_rdata == {DATA_W{1'b0}})); // R9

endmodule

// File: tb/flash_tick_prescaler_tb_top.sv
module flash_tick_prescaler_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmd_busy_i = 1'b0;
    logic       rst_seq_i = 1'b0;
    logic       tick_o;
    logic       div_valid_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_tick_prescaler dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cmd_busy_i  (cmd_busy_i),
        .rst_seq_i   (rst_seq_i),
        .tick_o      (tick_o),
        .div_valid_o (div_valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        cmd_busy_i = 1'b0;
        rst_seq_i = 1'b0;
        bus_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drives at a falling edge, the rising edge samples, returns at next falling edge
    task automatic do_write(input logic [3:0] a, input logic [7:0] d,
                            input logic busy, input logic seq);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        cmd_busy_i = busy;
        rst_seq_i = seq;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        cmd_busy_i = 1'b0;
        rst_seq_i = 1'b0;
        bus_addr = '0;
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input int exp);
        bus_addr = a;
        #1;
        chk(req, int'(bus_rdata), exp);
        bus_addr = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        read_chk("R1 rdata", 4'd0, 0);
        chk("R1 div_valid", int'(div_valid_o), 0);
        chk("R1 tick", int'(tick_o), 0);
        // R8 idle, no ticks
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R8 idle tick", int'(tick_o), 0);
            chk("R8 idle valid", int'(div_valid_o), 0);
        end

        // R9 other offsets ignored
        do_write(4'd3, 8'h15, 1'b0, 1'b0);
        read_chk("R9 read other", 4'd3, 0);
        read_chk("R9 reg untouched", 4'd0, 0);
        chk("R9 valid", int'(div_valid_o), 0);

        // R5 busy gate refuses and consumes nothing
        do_write(4'd0, 8'h22, 1'b1, 1'b0);
        read_chk("R5 refused", 4'd0, 0);
        chk("R5 valid", int'(div_valid_o), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 no tick", int'(tick_o), 0);
        end
        // R2 a later accepted write stores; bit 7 of wdata ignored (R4)
        do_write(4'd0, 8'h05, 1'b0, 1'b0);
        read_chk("R2 stored", 4'd0, 'h85);
        chk("R8 valid mirrors flag", int'(div_valid_o), 1);
        // R3 write-once
        do_write(4'd0, 8'h7A, 1'b0, 1'b0);
        read_chk("R3 locked", 4'd0, 'h85);
        do_write(4'd0, 8'h00, 1'b0, 1'b1);
        read_chk("R3 locked seq", 4'd0, 'h85);
        chk("R4 flag held", int'(div_valid_o), 1);

        // R6 override during reset sequence
        do_reset();
        do_write(4'd0, 8'h13, 1'b1, 1'b1);
        read_chk("R6 override", 4'd0, 'h93);
        // R4 writing bit 7 high with divider 0
        do_reset();
        do_write(4'd0, 8'h80, 1'b0, 1'b0);
        read_chk("R4 bit7 write", 4'd0, 'h80);
        do_reset();
        read_chk("R4 cleared by reset", 4'd0, 0);

        // R7 exhaustive sweep of divider values
        for (int d = 0; d < 128; d++) begin
            do_reset();
            do_write(4'd0, 8'(d), 1'b0, 1'b0);
            for (int k = 0; k < 3 * (d + 1); k++) begin
                chk($sformatf("R7 div=%0d k=%0d", d, k), int'(tick_o),
                    ((k % (d + 1)) == d) ? 1 : 0);
                @(negedge clk);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule